// File: doc/BRIEF.md
# ADC Conversion Sequencer with Clock Divider

This block is the digital control side of a successive-approximation converter. Software reaches it through one byte-wide control and status word that holds an enable, a start request, an automatic-start enable, a completion flag, an interrupt enable and a three-bit divider code. The block divides the system clock into a converter clock. It starts a conversion either on a software request or on a rising edge of one trigger line that the caller selects. It raises an interrupt request when a conversion finishes.

The analog part is replaced by a behavioural model. A conversion lasts a fixed number of converter-clock periods. It captures the `sample_in` value when it starts and presents that value on `result` when it ends. In the same system cycle the completion flag rises.

Top module: `adc_ctrl_unit`

## Requirements
- R1: After reset, `rd_data` reads 0, `irq` is low and no conversion runs.
- R2: The divider code sits in `rd_data[7:5]` and sets the converter clock period in system cycles: codes 0 and 1 give 2, and codes 2 to 7 give 4, 8, 16, 32, 64 and 128. Writing a 0 to the enable bit (`wr_data[0]`) returns the divider count to zero. A write that sets enable and start together, made after the block was disabled, therefore sets the completion flag exactly 13 × period system cycles after its write edge.
- R3: A conversion lasts 13 converter-clock periods. At its end the busy indication returns to 0.
- R4: `result` takes the value that `sample_in` held in the cycle the conversion was accepted. It changes only at the end of a conversion.
- R5: The completion flag (`rd_data[4]`) is set at the clock edge where `result` is updated. `irq` is high exactly when the flag, the interrupt enable (`rd_data[3]`) and `gie` are all 1.
- R6: A pulse on `irq_ack` clears the completion flag.
- R7: A write with `wr_data[4]` = 1 clears the completion flag. A write with `wr_data[4]` = 0 leaves the flag as it was.
- R8: Reading `rd_data` while the flag is set and writing that same byte back clears the flag.
- R9: When the automatic-start bit (`wr_data[2]`) is set, a 0-to-1 change on `trig_src[trig_sel]` starts a conversion. A trigger input held high starts nothing further. Edges on inputs that are not selected have no effect, and neither do edges while automatic start is off.
- R10: A trigger edge that comes while a conversion is running is dropped. It does not queue a second conversion.
- R11: If a conversion completes in the same cycle as a clear request, the flag ends up set.
- R12: Bit 1 of `rd_data` reads 1 while a conversion runs. A start request is accepted only when the same write also sets enable, or when enable is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word: [0] enable, [1] start, [2] auto start, [3] irq enable, [4] write 1 to clear flag, [7:5] divider code |
| rd_data | output | 8 | Status word: same layout as `wr_data`, with bit 1 showing busy and bit 4 showing the flag |
| trig_src | input | TRIG_N | Trigger candidate lines |
| trig_sel | input | SEL_W | Index of the active trigger line |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Conversion-complete interrupt request |
| sample_in | input | RES_W | Value the converter model captures at start |
| result | output | RES_W | Last conversion result |
| conv_tick | output | 1 | One-cycle pulse per converter-clock period |

## Verification
The bench uses the default parameters: a three-bit divider code, 13 periods per conversion, a 10-bit result and four trigger lines. With these values all eight divider codes run to completion. The slowest code takes 1664 system cycles, so the bench can count every one of them to the exact cycle. The short divide-by-2 conversion lets the bench place a clear request on the very cycle a conversion completes, and drive trigger edges while a conversion is still running.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  // bit positions of the control/status word
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_START = 1;
  localparam int unsigned B_AUTO  = 2;
  localparam int unsigned B_IE    = 3;
  localparam int unsigned B_FLAG  = 4;
  localparam int unsigned B_PSEL  = 5;

  // divider code to system cycles per converter-clock period
  function automatic int unsigned psel_div(input int unsigned code);
    return (code < 2) ? 32'd2 : (32'd1 << code);
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned PSEL_W = 3,
  localparam int unsigned CNT_W = (1 << PSEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'(adc_ctrl_pkg::psel_div(32'(psel)) - 1);
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int unsigned TRIG_N = 4,
  localparam int unsigned SEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIG_N-1:0] src,
  input  logic [SEL_W-1:0]  sel,
  output logic              rise
);
  logic [TRIG_N-1:0] prev;

  for (genvar g = 0; g < TRIG_N; g++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[g] <= 1'b0;
      else        prev[g] <= src[g];
    end
  end

  assign rise = src[sel] && !prev[sel];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (!rise || (sel != $past(sel)))); // R9
endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
  parameter int unsigned CYCLES = 13,
  parameter int unsigned RES_W  = 10,
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             start,
  input  logic [RES_W-1:0] sample,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  logic [CW-1:0]    tcnt;
  logic [RES_W-1:0] held;

  assign done = busy && tick && (tcnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tcnt   <= '0;
      held   <= '0;
      result <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      tcnt <= '0;
      held <= sample;
    end else if (!run) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (busy && tick) begin
      if (done) begin
        busy   <= 1'b0;
        result <= held;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(result)); // R4
endmodule

// File: rtl/adc_ctrl_unit.sv
module adc_ctrl_unit #(
  parameter int unsigned PSEL_W      = 3,
  parameter int unsigned CONV_CYCLES = 13,
  parameter int unsigned RES_W       = 10,
  parameter int unsigned TRIG_N      = 4,
  localparam int unsigned REG_W = 5 + PSEL_W,
  localparam int unsigned SEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [TRIG_N-1:0] trig_src,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic              gie,
  input  logic              irq_ack,
  output logic              irq,
  input  logic [RES_W-1:0]  sample_in,
  output logic [RES_W-1:0]  result,
  output logic              conv_tick
);
  import adc_ctrl_pkg::*;

  logic              en_q, auto_q, ie_q, flag_q;
  logic [PSEL_W-1:0] psel_q;
  logic              trig_rise, busy, conv_done;
  logic              sw_start, hw_start, conv_start, flag_clr;

  // named internal events
  assign sw_start   = wr_en && wr_data[B_EN] && wr_data[B_START];
  assign hw_start   = en_q && auto_q && trig_rise && !(wr_en && !wr_data[B_EN]);
  assign conv_start = sw_start || hw_start;
  assign flag_clr   = (wr_en && wr_data[B_FLAG]) || irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      ie_q   <= 1'b0;
      psel_q <= '0;
    end else if (wr_en) begin
      en_q   <= wr_data[B_EN];
      auto_q <= wr_data[B_AUTO];
      ie_q   <= wr_data[B_IE];
      psel_q <= wr_data[B_PSEL +: PSEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (conv_done) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  adc_clk_div #(.PSEL_W(PSEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_q), .psel(psel_q), .tick(conv_tick)
  );

  adc_trig_edge #(.TRIG_N(TRIG_N)) u_trig (
    .clk(clk), .rst_n(rst_n), .src(trig_src), .sel(trig_sel), .rise(trig_rise)
  );

  adc_conv_model #(.CYCLES(CONV_CYCLES), .RES_W(RES_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .run(en_q), .tick(conv_tick), .start(conv_start),
    .sample(sample_in), .busy(busy), .done(conv_done), .result(result)
  );

  assign rd_data = {psel_q, flag_q, ie_q, auto_q, busy, en_q};
  assign irq     = flag_q && ie_q && gie;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> flag_q); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !conv_done) |=> !flag_q); // R6
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_FLAG] && !conv_done) |=> !flag_q); // R7
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> en_q); // R12
endmodule

// File: tb/sim_adc_ctrl_unit.sv
module sim_adc_ctrl_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] trig_src = '0;
  logic [1:0] trig_sel = '0;
  logic       gie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic [9:0] sample_in = '0;
  logic [9:0] result;
  logic       conv_tick;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  adc_ctrl_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .trig_src(trig_src), .trig_sel(trig_sel), .gie(gie), .irq_ack(irq_ack), .irq(irq),
    .sample_in(sample_in), .result(result), .conv_tick(conv_tick)
  );

  function automatic int exp_div(input int code);
    int d = 2;
    for (int k = 2; k <= code; k++) d = d * 2;
    return d;
  endfunction

  function automatic logic [7:0] mk(input bit en, input bit st, input bit au,
                                    input bit ie, input bit fl, input int ps);
    return {ps[2:0], fl, ie, au, st, en};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=below 150000", cyc);
      finish_run();
    end
  end

  // aligned conversion with latency, busy and result checks
  task automatic run_conv(input int ps, input bit ie, input logic [9:0] smp);
    int n = 0;
    wr(mk(0, 0, 0, ie, 1, ps));
    @(negedge clk); sample_in = smp;
    wr(mk(1, 1, 0, ie, 0, ps));
    sample_in = ~smp;
    chk("R12 busy after start", rd_data[1], 1);
    while (!rd_data[4] && n < 5000) begin
      @(negedge clk); n++;
    end
    chk("R2/R3 latency", n, 13 * exp_div(ps));
    chk("R3 busy clear at end", rd_data[1], 0);
    chk("R4 result", result, smp);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R1 rd_data reset", rd_data, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 result reset", result, 0);
    rst_n = 1'b1;

    // R12: start without enable is ignored
    wr(mk(0, 1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    chk("R12 no start when disabled", rd_data[1], 0);

    // R2: every divider code
    for (int ps = 0; ps < 8; ps++) begin
      repeat ($urandom_range(0, 9)) @(negedge clk);
      run_conv(ps, 0, 10'($urandom));
      chk("R2 psel readback", rd_data[7:5], ps);
    end

    // R5/R7/R6: irq gating and clears
    run_conv(1, 1, 10'h2A5);
    gie = 1'b0; @(negedge clk);
    chk("R5 irq needs gie", irq, 0);
    gie = 1'b1; @(negedge clk);
    chk("R5 irq all set", irq, 1);
    wr(mk(1, 0, 0, 0, 0, 1));
    chk("R7 write zero keeps flag", rd_data[4], 1);
    chk("R5 irq needs ie", irq, 0);
    wr(mk(1, 0, 0, 1, 0, 1));
    chk("R5 irq back", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R6 ack clears flag", rd_data[4], 0);
    chk("R6 irq low after ack", irq, 0);
    run_conv(0, 0, 10'h155);
    wr(mk(1, 0, 0, 0, 1, 0));
    chk("R7 write one clears", rd_data[4], 0);

    // R8: read-modify-write
    run_conv(2, 1, 10'h0F0);
    begin
      logic [7:0] snap;
      snap = rd_data;
      chk("R8 flag read as one", snap[4], 1);
      wr(snap);
      chk("R8 write-back clears flag", rd_data[4], 0);
    end

    // R11: completion and clear in the same cycle
    begin
      int n = 0;
      wr(mk(0, 0, 0, 0, 0, 0));
      wr(mk(1, 1, 0, 0, 0, 0));
      while (n < 25) begin @(negedge clk); n++; end
      chk("R11 not yet done", rd_data[4], 0);
      wr_en = 1'b1; wr_data = mk(1, 0, 0, 0, 1, 0);
      @(negedge clk); wr_en = 1'b0;
      chk("R11 set wins over clear", rd_data[4], 1);
      wr(mk(1, 0, 0, 0, 1, 0));
    end

    // R9/R10: trigger behaviour
    trig_sel = 2'd2;
    wr(mk(1, 0, 0, 0, 1, 1));
    @(negedge clk); trig_src[2] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 edge ignored when auto off", rd_data[1], 0);
    trig_src[2] = 1'b0;
    wr(mk(1, 0, 1, 0, 1, 1));
    @(negedge clk); trig_src[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 unselected line ignored", rd_data[1], 0);
    trig_src[1] = 1'b0;
    trig_src[2] = 1'b1;
    @(negedge clk);
    chk("R9 rising edge starts", rd_data[1], 1);
    repeat (4) @(negedge clk);
    trig_src[2] = 1'b0; @(negedge clk);
    trig_src[2] = 1'b1; @(negedge clk);
    begin
      int n = 0;
      while (!rd_data[4] && n < 200) begin @(negedge clk); n++; end
    end
    chk("R9 trigger conversion done", rd_data[4], 1);
    wr(mk(1, 0, 1, 0, 1, 1));
    repeat (60) @(negedge clk);
    chk("R10 edge while busy not queued", rd_data[4], 0);
    chk("R9 held level starts nothing", rd_data[1], 0);
    trig_src[2] = 1'b0;

    // random mix
    for (int i = 0; i < 6; i++) begin
      int ps = $urandom_range(0, 5);
      bit ie = 1'($urandom);
      gie = 1'($urandom);
      run_conv(ps, ie, 10'($urandom));
      @(negedge clk);
      chk("R5 random irq", irq, ie & gie);
    end

    finish_run();
  end
endmodule